// File: doc/BRIEF.md
# External NMI Trap Controller

This block converts a falling edge on an asynchronous external non-maskable interrupt pin into a trap request for the processor. The pin is brought into the clock domain through a two-flop synchronizer. A one-to-zero transition of the synchronized level latches a pending request flag. The trap request output stays high while that request is pending and was enabled.

Software sees two byte-wide registers on a small register bus. The status register holds the pending flag and clears itself on every read. The control register holds three bits. The first is a one-shot enable, which hardware drops each time a request is latched and which software can raise only while nothing is pending. The second is a read-only copy of the synchronized pin level. The third is a lock-enable, which once written to 1 keeps NMIs enabled until reset.

Read data is registered: a read strobe in cycle N returns its data on `bus_rdata_o` in cycle N+1. Writes take effect at the clock edge that samples the strobe.

Top module: `nmi_trap_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the pending flag, the one-shot enable, the lock-enable and `trap_req_o` are all 0.
- R2: Only a 1-to-0 transition of the pin sets the pending flag. The flag is visible three clock edges after the pin falls, because of the two synchronizer flops and the edge register. A rising pin never sets it.
- R3: Address 0 is the status register. Its bit 0 is the pending flag and bits 7:1 read 0. A status read returns the value held before the read, and it clears the flag in that same cycle.
- R4: If a falling edge is latched in the same cycle as a status read, the read returns the old value and the flag ends set.
- R5: Address 1 is the control register. Bit 0 is the one-shot enable, bit 1 is the pin level and bit 2 is the lock-enable. Bits 7:3 read 0, and writes to them are ignored.
- R6: Hardware clears the one-shot enable in the cycle a falling edge is latched. This clear wins over a software write that sets the enable in the same cycle.
- R7: A control write with bit 0 set raises the one-shot enable only when the pending flag is 0. A control write with bit 0 clear drops the enable at any time.
- R8: Writing 1 to control bit 2 sets the lock-enable. Writing 0 to it is ignored, and only reset clears it.
- R9: While the lock-enable is set, a pending request drives `trap_req_o` high regardless of the one-shot enable.
- R10: Control bit 1 returns the synchronized pin level without inversion. Writes to it do not change it.
- R11: `trap_req_o` is high while the flag is pending and either the one-shot enable was set when the edge was latched or the lock-enable is set. It falls in the cycle after the clearing status read.
- R12: Reads of addresses 2 and 3 return 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_pin_i | input | 1 | Asynchronous external NMI pin, active on a falling edge |
| bus_en_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address: 0 status, 1 control |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid the cycle after a read strobe |
| trap_req_o | output | 1 | Trap request to the processor |

## Verification
Two pairs of functions can fall in the same clock edge. The first pair is a latched falling edge and a status read, which pulls the flag both ways. The second pair is a latched edge and a control write that sets the enable, which pulls the enable both ways. Each collision is provoked by dropping the pin and placing the bus strobe exactly two falling clock edges later, so that the strobe coincides with the edge-detect pulse. The status case is judged by the read returning 0x00 and a following read returning 0x01. The write case is judged by a control read-back showing the enable still 0.

// File: rtl/nmi_trap_pkg.sv
// Package: shared widths, register addresses and bit positions of the
// external NMI trap controller. Assumes a byte-wide register bus.
package nmi_trap_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] STATUS_ADDR = 2'd0;
    localparam logic [ADDR_W-1:0] CTRL_ADDR   = 2'd1;

    localparam int ST_FLAG_BIT = 0;
    localparam int CT_EN_BIT   = 0;
    localparam int CT_PIN_BIT  = 1;
    localparam int CT_LOCK_BIT = 2;

    // Decoded bus access for one cycle.
    typedef struct packed {
        logic status_rd;
        logic ctrl_rd;
        logic ctrl_wr;
    } reg_access_t;

    // Fields a control write may carry.
    typedef struct packed {
        logic en;
        logic lock;
    } ctrl_wr_t;

endpackage

// File: rtl/nmi_pin_sync.sv
// Module: nmi_pin_sync
// Brings the asynchronous NMI pin into the clock domain through a
// chain of STAGES flops. Assumes STAGES >= 2. The chain resets to
// RESET_LEVEL (idle-high pin), so no false falling edge is seen
// right after reset.
module nmi_pin_sync #(
    parameter int   STAGES      = 2,
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o
);

    logic [STAGES-1:0] stage_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First flop: sample the raw pin.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= RESET_LEVEL;
                else        stage_q[0] <= pin_i;
            end
        end else begin : g_next
            // Later flops: pass the previous stage on.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= RESET_LEVEL;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign level_o = stage_q[STAGES-1];

endmodule

// File: rtl/nmi_edge_det.sv
// Module: nmi_edge_det
// Flags a 1-to-0 transition of the synchronized pin level. Assumes
// level_i is already synchronous. fall_o is high for one cycle.
module nmi_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic fall_o
);

    logic prev_q;

    // Remember the level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= level_i;
    end

    assign fall_o = prev_q & ~level_i;

    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o); // R2

endmodule

// File: rtl/nmi_req_ctrl.sv
// Module: nmi_req_ctrl
// Holds the pending request flag, the one-shot enable, the sticky lock
// and the armed state, and forms the trap request. Assumes fall_i is
// a single-cycle pulse. An edge wins over a clearing read, and the
// hardware clear of the enable wins over a software set.
module nmi_req_ctrl
    import nmi_trap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fall_i,
    input  reg_access_t acc_i,
    input  ctrl_wr_t    wr_i,
    output logic        flag_o,
    output logic        en_o,
    output logic        lock_o,
    output logic        trap_req_o
);

    logic flag_q;
    logic en_q;
    logic lock_q;
    logic armed_q;
    logic enabled_now;
    logic armed_keep;

    assign enabled_now = en_q | lock_q;
    assign armed_keep  = armed_q & ~acc_i.status_rd;

    // Pending flag: set by an edge, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)               flag_q <= 1'b0;
        else if (fall_i)          flag_q <= 1'b1;
        else if (acc_i.status_rd) flag_q <= 1'b0;
    end

    // Armed: the request was enabled when it arrived.
    always_ff @(posedge clk) begin
        if (!rst_n)               armed_q <= 1'b0;
        else if (fall_i)          armed_q <= armed_keep | enabled_now;
        else if (acc_i.status_rd) armed_q <= 1'b0;
    end

    // One-shot enable: hardware clear first, then software write rules.
    always_ff @(posedge clk) begin
        if (!rst_n)             en_q <= 1'b0;
        else if (fall_i)        en_q <= 1'b0;
        else if (acc_i.ctrl_wr) begin
            if (!wr_i.en)       en_q <= 1'b0;
            else if (!flag_q)   en_q <= 1'b1;
        end
    end

    // Lock-enable: set by software, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                        lock_q <= 1'b0;
        else if (acc_i.ctrl_wr && wr_i.lock) lock_q <= 1'b1;
    end

    assign trap_req_o = flag_q & (armed_q | lock_q);
    assign flag_o     = flag_q;
    assign en_o       = en_q;
    assign lock_o     = lock_q;

    AST_FLAG_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(fall_i)); // R2
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i.status_rd && !fall_i) |=> !flag_q); // R3
    AST_EDGE_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i.status_rd && fall_i) |=> flag_q); // R4
    AST_EN_DROPS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i |=> !en_q); // R6
    AST_EN_NO_SET_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> !$past(flag_q)); // R7
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q); // R8
    AST_LOCK_FORCES_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && flag_q) |-> trap_req_o); // R9
    AST_TRAP_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req_o |-> flag_q); // R11

endmodule

// File: rtl/nmi_reg_if.sv
// Module: nmi_reg_if
// Decodes the register bus and returns registered read data one cycle
// after a read strobe. Assumes one strobe per access. Unknown addresses
// read 0 and writes to them are dropped.
module nmi_reg_if
    import nmi_trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              flag_i,
    input  logic              en_i,
    input  logic              pin_i,
    input  logic              lock_i,
    output reg_access_t       acc_o,
    output ctrl_wr_t          wr_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] rdata_d;
    logic [DATA_W-1:0] rdata_q;
    logic              any_rd;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata_i[DATA_W-1:CT_LOCK_BIT+1] ^ bus_wdata_i[CT_PIN_BIT];

    // Decode the strobe into per-register accesses.
    always_comb begin
        acc_o           = '0;
        acc_o.status_rd = bus_en_i && !bus_wr_i && (bus_addr_i == STATUS_ADDR);
        acc_o.ctrl_rd   = bus_en_i && !bus_wr_i && (bus_addr_i == CTRL_ADDR);
        acc_o.ctrl_wr   = bus_en_i &&  bus_wr_i && (bus_addr_i == CTRL_ADDR);
    end

    assign wr_o.en   = bus_wdata_i[CT_EN_BIT];
    assign wr_o.lock = bus_wdata_i[CT_LOCK_BIT];
    assign any_rd    = bus_en_i && !bus_wr_i;

    // Build the read word for the addressed register.
    always_comb begin
        rdata_d = '0;
        if (acc_o.status_rd) begin
            rdata_d[ST_FLAG_BIT] = flag_i;
        end else if (acc_o.ctrl_rd) begin
            rdata_d[CT_EN_BIT]   = en_i;
            rdata_d[CT_PIN_BIT]  = pin_i;
            rdata_d[CT_LOCK_BIT] = lock_i;
        end
    end

    // Register the read word on every read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (any_rd) rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;

    AST_STATUS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_o.status_rd) |-> (rdata_q[DATA_W-1:1] == '0)); // R3
    AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_o.ctrl_rd) |-> (rdata_q[DATA_W-1:CT_LOCK_BIT+1] == '0)); // R5
    AST_OTHER_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(any_rd && !acc_o.status_rd && !acc_o.ctrl_rd) |-> (rdata_q == '0)); // R12

endmodule

// File: rtl/nmi_trap_ctrl.sv
// Module: nmi_trap_ctrl (top)
// External NMI trap controller: it synchronizes the pin, detects falling
// edges, keeps the request and enable state, and serves the status and
// control registers. Assumes a single clock and a synchronous active-low
// reset, with the pin idle high.
module nmi_trap_ctrl
    import nmi_trap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_pin_i,
    input  logic              bus_en_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              trap_req_o
);

    logic        pin_level;
    logic        fall;
    logic        flag;
    logic        en;
    logic        lock;
    reg_access_t acc;
    ctrl_wr_t    wr;

    nmi_pin_sync #(
        .STAGES      (SYNC_STAGES),
        .RESET_LEVEL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (nmi_pin_i),
        .level_o (pin_level)
    );

    nmi_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pin_level),
        .fall_o  (fall)
    );

    nmi_req_ctrl u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_i     (fall),
        .acc_i      (acc),
        .wr_i       (wr),
        .flag_o     (flag),
        .en_o       (en),
        .lock_o     (lock),
        .trap_req_o (trap_req_o)
    );

    nmi_reg_if u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_en_i    (bus_en_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .flag_i      (flag),
        .en_i        (en),
        .pin_i       (pin_level),
        .lock_i      (lock),
        .acc_o       (acc),
        .wr_o        (wr),
        .rdata_o     (bus_rdata_o)
    );

    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |=> (!trap_req_o && !flag && !en && !lock)); // R1
    AST_PIN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc.ctrl_rd) |-> (bus_rdata_o[CT_PIN_BIT] == $past(pin_level))); // R10

endmodule

// File: tb/nmi_trap_ctrl_test.sv
// Bench for nmi_trap_ctrl: a scoreboard of expected read words is filled
// by the driver tasks and drained by a monitor one cycle after each read.
module nmi_trap_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_pin = 1'b1;
    logic       bus_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       trap_req;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    logic rd_seen = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    nmi_trap_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .nmi_pin_i   (nmi_pin),
        .bus_en_i    (bus_en),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .trap_req_o  (trap_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Mark cycles whose read data is due on the next falling edge.
    always @(posedge clk) rd_seen <= bus_en & ~bus_wr;

    // Monitor: compare returned read data with the scoreboard head.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL scoreboard empty: got %02h expected none", bus_rdata);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                n_tests++;
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s read: got %02h expected %02h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic check_trap(input logic e, input string t);
        n_tests++;
        if (trap_req !== e) begin
            n_fail++;
            $display("FAIL %s trap_req: got %0b expected %0b", t, trap_req, e);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; nmi_pin = 1'b1;
        settle(3);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    // Stimulus; control read word is {lock,pin,en} in bits 2:0.
    initial begin
        do_reset();
        check_trap(1'b0, "R1");
        bus_read(2'd0, 8'h00, "R1 status");
        bus_read(2'd1, 8'h02, "R1 R5 control");

        // R2 R10: falling edge without enable
        @(negedge clk); nmi_pin = 1'b0;
        settle(3);
        check_trap(1'b0, "R11 disabled");
        bus_read(2'd1, 8'h00, "R10 pin low");
        bus_read(2'd0, 8'h01, "R2 R3 flag");
        bus_read(2'd0, 8'h00, "R3 cleared");
        bus_write(2'd1, 8'h02);
        bus_read(2'd1, 8'h00, "R10 pin write ignored");

        // R2: rising edge sets nothing
        @(negedge clk); nmi_pin = 1'b1;
        settle(3);
        bus_read(2'd0, 8'h00, "R2 rising");
        bus_read(2'd1, 8'h02, "R10 pin high");

        // R7 R6 R11: enabled edge
        bus_write(2'd1, 8'h01);
        bus_read(2'd1, 8'h03, "R7 set");
        check_trap(1'b0, "R11 idle");
        @(negedge clk); nmi_pin = 1'b0;
        settle(3);
        check_trap(1'b1, "R11 taken");
        bus_read(2'd1, 8'h00, "R6 hw clear");
        check_trap(1'b1, "R11 holds");
        bus_read(2'd0, 8'h01, "R3 flag");
        check_trap(1'b0, "R11 after read");

        // R7: set blocked while pending
        @(negedge clk); nmi_pin = 1'b1;
        settle(3);
        @(negedge clk); nmi_pin = 1'b0;
        settle(3);
        bus_write(2'd1, 8'h01);
        bus_read(2'd1, 8'h00, "R7 blocked");
        bus_read(2'd0, 8'h01, "R7 pending");
        bus_write(2'd1, 8'h01);
        bus_read(2'd1, 8'h01, "R7 allowed");
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, 8'h00, "R7 clear");

        // R12: other addresses
        bus_write(2'd2, 8'h05);
        bus_write(2'd3, 8'h05);
        bus_read(2'd1, 8'h00, "R12 no effect");
        bus_read(2'd2, 8'h00, "R12 addr2");
        bus_read(2'd3, 8'h00, "R12 addr3");

        // R4: edge and status read in the same cycle
        @(negedge clk); nmi_pin = 1'b1;
        settle(3);
        @(negedge clk); nmi_pin = 1'b0;
        @(negedge clk);
        bus_read(2'd0, 8'h00, "R4 collide old");
        bus_read(2'd0, 8'h01, "R4 flag kept");

        // R6: edge and enable-set write in the same cycle
        @(negedge clk); nmi_pin = 1'b1;
        settle(3);
        @(negedge clk); nmi_pin = 1'b0;
        @(negedge clk);
        bus_write(2'd1, 8'h01);
        bus_read(2'd1, 8'h00, "R6 hw wins");
        check_trap(1'b0, "R6 R11 unarmed");
        bus_read(2'd0, 8'h01, "R6 flag");

        // R5: reserved bits ignored
        bus_write(2'd1, 8'hF9);
        bus_read(2'd1, 8'h01, "R5 reserved");

        // R8 R9: lock
        bus_write(2'd1, 8'h04);
        bus_read(2'd1, 8'h04, "R8 lock set");
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, 8'h04, "R8 lock sticky");
        @(negedge clk); nmi_pin = 1'b1;
        settle(3);
        @(negedge clk); nmi_pin = 1'b0;
        settle(3);
        check_trap(1'b1, "R9 lock forces");
        bus_read(2'd1, 8'h04, "R9 en ignored");
        bus_read(2'd0, 8'h01, "R9 flag");
        check_trap(1'b0, "R9 R11 cleared");

        // R8 R1: reset clears lock
        do_reset();
        check_trap(1'b0, "R1 again");
        bus_read(2'd1, 8'h02, "R8 reset clears lock");
        bus_read(2'd0, 8'h00, "R1 status again");

        settle(3);
        if (exp_q.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL scoreboard: got %0d left expected 0", exp_q.size());
        end
        summary();
    end

endmodule